// File: doc/BRIEF.md
# FIFO-to-Memory Burst Transfer Engine

This engine moves words without software help between an on-chip FIFO and a circular buffer held in external memory. One instance is built for each direction. In the receive build, the engine drains the FIFO and writes into the region. In the transmit build, it reads from the region and refills the FIFO. Because each direction has its own instance, the two run side by side. Software sets the region's base and size for each instance, so memory can be split between directions in any proportion.

Each cycle, the engine compares three quantities: what the FIFO offers (stored words on receive, free slots on transmit), what the region offers (free words on receive, stored words on transmit), and the distance from its own pointer to the top of the region. It issues an 8-word burst when all three allow it. It issues a one-word transfer when at least one word can move but a full burst cannot. Only one memory request is open at a time, and state changes only when that request is acknowledged. The far side of the buffer is advanced by a host-side strobe carrying a word count. This is how a DMA engine reports the words it has taken from, or placed into, the region.

The pointers, the occupancy and a sticky stall flag are brought out for software to read.

Top module: `fifo_mem_mover`

## Requirements
- R1: When the engine is enabled and idle, and the FIFO figure, the region figure and the distance from the engine pointer to base+size are each at least 8, it raises `mem_req` with `mem_burst`=1, `mem_len`=8 and `mem_addr` equal to the engine pointer.
- R2: When at least one word can move but any of those three figures is below 8, the request is a single transfer: `mem_burst`=0 and `mem_len`=1.
- R3: No burst spans the top of the region. The engine pointer advances by the request length on acknowledge and returns to base when it reaches base+size.
- R4: A receive instance issues no request while occupancy equals size. A transmit instance issues no request while occupancy is zero.
- R5: At most one request is open. `mem_req`, `mem_addr`, `mem_len` and `mem_burst` hold steady until `mem_ack`. The engine pointer and the engine's share of occupancy change only on the acknowledge cycle.
- R6: A `host_adv` strobe moves the host-side pointer by `host_len` (with wrap) and changes occupancy by that amount (down on receive, up on transmit). If it coincides with an acknowledge, occupancy takes the net of both changes.
- R7: `occupancy` reads the region's stored word count and never exceeds size.
- R8: `stall_flag` sets while enabled when the FIFO is at its limit and the region blocks. On receive, the limit is `fifo_avail`=FIFO_DEPTH stored words with the region full. On transmit, it is `fifo_avail`=FIFO_DEPTH free slots with the region empty. Only reset clears the flag.
- R9: `cfg_init` resets both pointers to base and occupancy to 0, and withdraws any open request. While `cfg_enable` is 0, no new request is issued.
- R10: On the acknowledge cycle, `fifo_move` is 1 and `fifo_move_len` equals the granted length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Region base word address |
| cfg_size | input | ADDR_W | Region size in words |
| cfg_init | input | 1 | Reset pointers and occupancy to the region start |
| cfg_enable | input | 1 | Allow new requests |
| fifo_avail | input | LVL_W | FIFO stored words (receive) or free slots (transmit) |
| fifo_move | output | 1 | Words move on the FIFO side this cycle |
| fifo_move_len | output | LEN_W | Number of words moved |
| mem_req | output | 1 | Memory request open |
| mem_burst | output | 1 | 1 = 8-word burst, 0 = single word |
| mem_len | output | LEN_W | Request length in words |
| mem_addr | output | ADDR_W | Request start word address |
| mem_ack | input | 1 | Request granted |
| host_adv | input | 1 | Host side moved words through the region |
| host_len | input | ADDR_W | Word count of the host move |
| wr_ptr | output | ADDR_W | Region write pointer |
| rd_ptr | output | ADDR_W | Region read pointer |
| occupancy | output | ADDR_W | Stored words in the region |
| stall_flag | output | 1 | Sticky FIFO-at-limit-while-region-blocked flag |

## Verification
An acknowledge from the memory side and a host advance strobe can land in the same clock edge, and both change the occupancy count. The bench raises `host_adv` with a length of 5 on the same cycle that it acknowledges an 8-word receive burst. It then expects the count to move by +3, with the write pointer and read pointer each advanced by its own amount. A later host advance wraps the read pointer while an engine request is still waiting. This shows the open request stays frozen while the other side changes.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  typedef enum logic [0:0] {
    MV_IDLE = 1'b0,
    MV_REQ  = 1'b1
  } mv_state_e;
endpackage

// File: rtl/fmm_pick.sv
// Chooses between burst, single or no transfer from the three limits.
module fmm_pick #(
  parameter int ADDR_W = 16,
  parameter int LVL_W  = 6,
  parameter int BURST  = 8
) (
  input  logic              enable,
  input  logic [LVL_W-1:0]  fifo_avail,
  input  logic [ADDR_W-1:0] region_avail,
  input  logic [ADDR_W:0]   dist_to_end,
  output logic              go,
  output logic              burst
);
  logic fifo_one, fifo_full_burst, reg_one, reg_full_burst, room_burst;

  always_comb begin
    fifo_one        = fifo_avail != '0;
    fifo_full_burst = fifo_avail >= LVL_W'(BURST);
    reg_one         = region_avail != '0;
    reg_full_burst  = region_avail >= ADDR_W'(BURST);
    room_burst      = dist_to_end >= (ADDR_W+1)'(BURST);
    go    = enable && fifo_one && reg_one;
    burst = go && fifo_full_burst && reg_full_burst && room_burst;
  end
endmodule

// File: rtl/fmm_ring_step.sv
// Advances a pointer inside a circular region, wrapping at base+size.
module fmm_ring_step #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W:0] sum, top;

  always_comb begin
    sum = {1'b0, ptr} + {1'b0, step};
    top = {1'b0, base} + {1'b0, size};
    if (sum >= top) nxt = ADDR_W'(sum - {1'b0, size});
    else            nxt = sum[ADDR_W-1:0];
  end
endmodule

// File: rtl/fmm_occ.sv
// Region occupancy counter and sticky stall flag.
module fmm_occ #(
  parameter int ADDR_W     = 16,
  parameter int LVL_W      = 6,
  parameter int LEN_W      = 4,
  parameter int FIFO_DEPTH = 32,
  parameter bit DIR_RX     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              enable,
  input  logic [ADDR_W-1:0] size,
  input  logic              eng_ack,
  input  logic [LEN_W-1:0]  eng_len,
  input  logic              host_adv,
  input  logic [ADDR_W-1:0] host_len,
  input  logic [LVL_W-1:0]  fifo_avail,
  output logic [ADDR_W-1:0] count,
  output logic              full,
  output logic              empty,
  output logic              stall
);
  logic [ADDR_W-1:0] cnt_q, cnt_d, eng_amt, host_amt;
  logic [ADDR_W:0]   cnt_calc;
  logic              cnt_en, stall_q, stall_d, fifo_at_limit;

  always_comb begin
    eng_amt  = eng_ack  ? ADDR_W'(eng_len) : '0;
    host_amt = host_adv ? host_len         : '0;
    if (DIR_RX) cnt_calc = {1'b0, cnt_q} + {1'b0, eng_amt} - {1'b0, host_amt};
    else        cnt_calc = {1'b0, cnt_q} + {1'b0, host_amt} - {1'b0, eng_amt};
    cnt_en = init || eng_ack || host_adv;
    cnt_d  = init ? '0 : cnt_calc[ADDR_W-1:0];
    fifo_at_limit = fifo_avail == LVL_W'(FIFO_DEPTH);
    stall_d = stall_q ||
              (enable && fifo_at_limit && (DIR_RX ? full : empty));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stall_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      stall_q <= stall_d;
    end
  end

  assign count = cnt_q;
  assign full  = cnt_q == size;
  assign empty = cnt_q == '0;
  assign stall = stall_q;

  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= size);
  // R8
  stall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> stall);
  // R5
  occ_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(init || eng_ack || host_adv) |=> $stable(count));
endmodule

// File: rtl/fifo_mem_mover.sv
module fifo_mem_mover
  import fmm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BURST      = 8,
  parameter int FIFO_DEPTH = 32,
  parameter bit DIR_RX     = 1'b1,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int LEN_W     = $clog2(BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_size,
  input  logic              cfg_init,
  input  logic              cfg_enable,
  input  logic [LVL_W-1:0]  fifo_avail,
  output logic              fifo_move,
  output logic [LEN_W-1:0]  fifo_move_len,
  output logic              mem_req,
  output logic              mem_burst,
  output logic [LEN_W-1:0]  mem_len,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic              host_adv,
  input  logic [ADDR_W-1:0] host_len,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W-1:0] occupancy,
  output logic              stall_flag
);
  mv_state_e         st_q, st_d;
  logic              rq_burst_q, rq_burst_d;
  logic [LEN_W-1:0]  rq_len_q, rq_len_d;
  logic [ADDR_W-1:0] rq_addr_q, rq_addr_d;
  logic [ADDR_W-1:0] eng_ptr_q, host_ptr_q, eng_ptr_nxt, host_ptr_nxt;
  logic [ADDR_W-1:0] region_avail, occ_cnt;
  logic [ADDR_W:0]   region_top, dist_to_end;
  logic              ack_fire, rq_load, pick_go, pick_burst;
  logic              occ_full, occ_empty;

  assign ack_fire    = (st_q == MV_REQ) && mem_ack && !cfg_init;
  assign region_top  = {1'b0, cfg_base} + {1'b0, cfg_size};
  assign dist_to_end = region_top - {1'b0, eng_ptr_q};
  assign region_avail = DIR_RX ? (cfg_size - occ_cnt) : occ_cnt;

  fmm_pick #(.ADDR_W(ADDR_W), .LVL_W(LVL_W), .BURST(BURST)) u_pick (
    .enable      (cfg_enable),
    .fifo_avail  (fifo_avail),
    .region_avail(region_avail),
    .dist_to_end (dist_to_end),
    .go          (pick_go),
    .burst       (pick_burst)
  );

  fmm_ring_step #(.ADDR_W(ADDR_W)) u_eng_step (
    .base(cfg_base), .size(cfg_size), .ptr(eng_ptr_q),
    .step(ADDR_W'(rq_len_q)), .nxt(eng_ptr_nxt)
  );

  fmm_ring_step #(.ADDR_W(ADDR_W)) u_host_step (
    .base(cfg_base), .size(cfg_size), .ptr(host_ptr_q),
    .step(host_len), .nxt(host_ptr_nxt)
  );

  fmm_occ #(
    .ADDR_W(ADDR_W), .LVL_W(LVL_W), .LEN_W(LEN_W),
    .FIFO_DEPTH(FIFO_DEPTH), .DIR_RX(DIR_RX)
  ) u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (cfg_init),
    .enable    (cfg_enable),
    .size      (cfg_size),
    .eng_ack   (ack_fire),
    .eng_len   (rq_len_q),
    .host_adv  (host_adv && !cfg_init),
    .host_len  (host_len),
    .fifo_avail(fifo_avail),
    .count     (occ_cnt),
    .full      (occ_full),
    .empty     (occ_empty),
    .stall     (stall_flag)
  );

  // Next-state and request capture
  always_comb begin
    st_d       = st_q;
    rq_burst_d = rq_burst_q;
    rq_len_d   = rq_len_q;
    rq_addr_d  = rq_addr_q;
    unique case (st_q)
      MV_IDLE: begin
        if (!cfg_init && pick_go) begin
          st_d       = MV_REQ;
          rq_burst_d = pick_burst;
          rq_len_d   = pick_burst ? LEN_W'(BURST) : LEN_W'(1);
          rq_addr_d  = eng_ptr_q;
        end
      end
      MV_REQ: begin
        if (cfg_init || mem_ack) st_d = MV_IDLE;
      end
      default: st_d = MV_IDLE;
    endcase
  end

  assign rq_load = (st_q == MV_IDLE) && (st_d == MV_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= MV_IDLE;
      rq_burst_q <= 1'b0;
      rq_len_q   <= '0;
      rq_addr_q  <= '0;
    end else begin
      st_q <= st_d;
      if (rq_load) begin
        rq_burst_q <= rq_burst_d;
        rq_len_q   <= rq_len_d;
        rq_addr_q  <= rq_addr_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_ptr_q  <= '0;
      host_ptr_q <= '0;
    end else if (cfg_init) begin
      eng_ptr_q  <= cfg_base;
      host_ptr_q <= cfg_base;
    end else begin
      if (ack_fire) eng_ptr_q  <= eng_ptr_nxt;
      if (host_adv) host_ptr_q <= host_ptr_nxt;
    end
  end

  generate
    if (DIR_RX) begin : g_rx
      assign wr_ptr = eng_ptr_q;
      assign rd_ptr = host_ptr_q;
    end else begin : g_tx
      assign wr_ptr = host_ptr_q;
      assign rd_ptr = eng_ptr_q;
    end
  endgenerate

  assign mem_req       = st_q == MV_REQ;
  assign mem_burst     = rq_burst_q;
  assign mem_len       = rq_len_q;
  assign mem_addr      = rq_addr_q;
  assign fifo_move     = ack_fire;
  assign fifo_move_len = rq_len_q;
  assign occupancy     = occ_cnt;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !cfg_init) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_burst)));
  // R3
  no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_burst && !cfg_init) |->
      (({1'b0, mem_addr} + (ADDR_W+1)'(BURST)) <= region_top));
  // R4
  region_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !cfg_init) |-> (DIR_RX ? !occ_full : !occ_empty));
  // R2
  len_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len == (mem_burst ? LEN_W'(BURST) : LEN_W'(1))));
  // R9
  init_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_init |=> !mem_req);
endmodule

// File: tb/fifo_mem_mover_tb.sv
module fifo_mem_mover_tb;
  localparam int AW = 16;

  logic clk, rst_n;
  int   n_chk, n_err, cyc;

  // receive instance signals
  logic [AW-1:0] base, size, hlen, wrp, rdp, occ, addr;
  logic init, en, move, req, bst, ack, hadv, stl;
  logic [5:0] favail;
  logic [3:0] mlen, len;

  // transmit instance signals
  logic [AW-1:0] t_base, t_size, t_hlen, t_wrp, t_rdp, t_occ, t_addr;
  logic t_init, t_en, t_move, t_req, t_bst, t_ack, t_hadv, t_stl;
  logic [5:0] t_favail;
  logic [3:0] t_mlen, t_len;

  fifo_mem_mover #(.DIR_RX(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(base), .cfg_size(size),
    .cfg_init(init), .cfg_enable(en), .fifo_avail(favail),
    .fifo_move(move), .fifo_move_len(mlen), .mem_req(req), .mem_burst(bst),
    .mem_len(len), .mem_addr(addr), .mem_ack(ack), .host_adv(hadv),
    .host_len(hlen), .wr_ptr(wrp), .rd_ptr(rdp), .occupancy(occ),
    .stall_flag(stl));

  fifo_mem_mover #(.DIR_RX(1'b0)) u_tx (
    .clk(clk), .rst_n(rst_n), .cfg_base(t_base), .cfg_size(t_size),
    .cfg_init(t_init), .cfg_enable(t_en), .fifo_avail(t_favail),
    .fifo_move(t_move), .fifo_move_len(t_mlen), .mem_req(t_req),
    .mem_burst(t_bst), .mem_len(t_len), .mem_addr(t_addr), .mem_ack(t_ack),
    .host_adv(t_hadv), .host_len(t_hlen), .wr_ptr(t_wrp), .rd_ptr(t_rdp),
    .occupancy(t_occ), .stall_flag(t_stl));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        finish_run();
      end
    end
  end

  // Wait for a request, check it, acknowledge it (optionally with host move).
  task automatic serve(input bit tx, input int exp_addr, input bit exp_burst,
                       input int hmove, input string tag);
    int w = 0;
    while (((tx ? t_req : req) !== 1'b1) && w < 60) begin
      @(negedge clk); w++;
    end
    chk({tag, " req seen"}, int'(tx ? t_req : req), 1);
    chk({tag, " addr"}, int'(tx ? t_addr : addr), exp_addr);
    chk({tag, " burst"}, int'(tx ? t_bst : bst), int'(exp_burst));
    chk({tag, " len"}, int'(tx ? t_len : len), exp_burst ? 8 : 1);
    if (tx) t_ack = 1'b1; else ack = 1'b1;
    if (hmove > 0) begin
      if (tx) begin t_hadv = 1'b1; t_hlen = AW'(hmove); end
      else begin hadv = 1'b1; hlen = AW'(hmove); end
    end
    #1;
    // R10: FIFO side strobe on the acknowledge cycle
    chk({tag, " R10 move"}, int'(tx ? t_move : move), 1);
    chk({tag, " R10 move_len"}, int'(tx ? t_mlen : mlen), exp_burst ? 8 : 1);
    @(negedge clk);
    ack = 1'b0; t_ack = 1'b0; hadv = 1'b0; t_hadv = 1'b0;
  endtask

  task automatic host_move(input bit tx, input int n);
    if (tx) begin t_hadv = 1'b1; t_hlen = AW'(n); end
    else begin hadv = 1'b1; hlen = AW'(n); end
    @(negedge clk);
    hadv = 1'b0; t_hadv = 1'b0;
  endtask

  task automatic quiet(input bit tx, input int ncyc, input string tag);
    int seen = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if ((tx ? t_req : req) === 1'b1) seen++;
    end
    chk(tag, seen, 0);
  endtask

  task automatic t_reset();
    chk("reset R5 req", int'(req), 0);
    chk("reset R7 occ", int'(occ), 0);
    chk("reset R8 flag", int'(stl), 0);
    chk("reset tx req", int'(t_req), 0);
  endtask

  task automatic t_rx_fill();
    init = 1'b1; @(negedge clk); init = 1'b0;
    chk("R9 init wr_ptr", int'(wrp), 100);
    favail = 6'd3; en = 1'b1;
    serve(0, 100, 0, 0, "R2 short fifo single");
    favail = 6'd20;
    serve(0, 101, 1, 0, "R1 burst a");
    serve(0, 109, 1, 0, "R1 burst b");
    chk("R7 occ after bursts", int'(occ), 17);
    serve(0, 117, 0, 0, "R2 region near full single");
    serve(0, 118, 0, 0, "R2 single b");
    serve(0, 119, 0, 0, "R3 last single");
    chk("R3 wr_ptr wrap", int'(wrp), 100);
    chk("R7 occ full", int'(occ), 20);
    quiet(0, 10, "R4 rx full no request");
    chk("R8 flag clear before limit", int'(stl), 0);
    favail = 6'd32; @(negedge clk);
    chk("R8 flag set", int'(stl), 1);
    favail = 6'd20; @(negedge clk);
    chk("R8 flag sticky", int'(stl), 1);
  endtask

  task automatic t_rx_host();
    host_move(0, 10);
    chk("R6 rd_ptr", int'(rdp), 110);
    chk("R6 occ after host", int'(occ), 10);
    // ack and host advance on the same edge
    serve(0, 100, 1, 5, "R6 concurrent");
    chk("R6 net occ", int'(occ), 13);
    chk("R6 rd_ptr concurrent", int'(rdp), 115);
    chk("R3 wr_ptr concurrent", int'(wrp), 108);
    // next request (single, space 7) waits while host wraps
    @(negedge clk); @(negedge clk);
    chk("R5 pending req", int'(req), 1);
    host_move(0, 10);
    chk("R6 rd_ptr wrap", int'(rdp), 105);
    chk("R5 addr held", int'(addr), 108);
    chk("R5 burst held", int'(bst), 0);
    serve(0, 108, 0, 0, "R2 latched single");
    serve(0, 109, 1, 0, "R1 burst after wrap");
    chk("R7 occ mid", int'(occ), 12);
    serve(0, 117, 0, 0, "R3 dist short single");
    @(negedge clk); @(negedge clk);
    chk("R9 req before init", int'(req), 1);
    en = 1'b0; init = 1'b1; @(negedge clk); init = 1'b0;
    chk("R9 req dropped", int'(req), 0);
    chk("R9 wr_ptr", int'(wrp), 100);
    chk("R9 rd_ptr", int'(rdp), 100);
    chk("R9 occ", int'(occ), 0);
    quiet(0, 6, "R9 disabled no request");
    chk("R8 flag survives init", int'(stl), 1);
  endtask

  task automatic t_tx();
    t_init = 1'b1; @(negedge clk); t_init = 1'b0;
    t_favail = 6'd32; t_en = 1'b1;
    quiet(1, 6, "R4 tx empty no request");
    chk("R8 tx starve flag", int'(t_stl), 1);
    host_move(1, 12);
    chk("R6 tx wr_ptr", int'(t_wrp), 212);
    chk("R6 tx occ", int'(t_occ), 12);
    serve(1, 200, 1, 0, "R1 tx burst");
    serve(1, 208, 0, 0, "R2 tx single a");
    serve(1, 209, 0, 0, "R2 tx single b");
    serve(1, 210, 0, 0, "R2 tx single c");
    serve(1, 211, 0, 0, "R2 tx single d");
    chk("R3 tx rd_ptr", int'(t_rdp), 212);
    chk("R7 tx occ", int'(t_occ), 0);
    quiet(1, 6, "R4 tx drained");
  endtask

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0;
    base = 16'd100; size = 16'd20; init = 1'b0; en = 1'b0; favail = '0;
    ack = 1'b0; hadv = 1'b0; hlen = '0;
    t_base = 16'd200; t_size = 16'd16; t_init = 1'b0; t_en = 1'b0;
    t_favail = '0; t_ack = 1'b0; t_hadv = 1'b0; t_hlen = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_fill();
    t_rx_host();
    t_tx();
    finish_run();
  end
endmodule